// File: doc/BRIEF.md
# Addressed Serial Message Receiver

This block takes in asynchronous serial characters on a single line and decides which of them belong to this station. Each character frame holds ten bit periods: a low start bit, seven data bits sent least significant bit first, a parity bit and a high stop bit. A frame sequencer times every bit from the fast system clock and samples each data bit at the middle of its period into a seven-bit character register. The parity bit's value is not checked.

A header state machine reads each completed character at the middle of its parity period. A message opens with the start-of-text code. The next character must equal the station's wired address. Once both have matched, every further character of the message is passed on to the next buffer stage. The character register is emptied serially, one bit per fast clock over seven clocks, long before the next frame's first data bit arrives. The end-of-text code closes the message.

The header machine has four states. WAIT_STX moves to WAIT_ADDR when the start-of-text code arrives, to DISCARD on any other code, and stays put on end-of-text. WAIT_ADDR moves to PASS on an address match, to DISCARD on a mismatch, and back to WAIT_STX on end-of-text. PASS forwards every character and returns to WAIT_STX on end-of-text. DISCARD waits for end-of-text and then returns to WAIT_STX. The frame sequencer runs IDLE → START → DATA → PARITY → STOP → IDLE, with a false-start exit from START back to IDLE. The handoff unit runs IDLE → ARMED → SHIFT → IDLE.

Top module: `addr_serial_rx`

## Requirements
- R1: While reset is asserted and directly after it, `stx_seen`, `addr_ok`, `hand_strobe` and `hand_data` are low, and the header machine is in WAIT_STX.
- R2: A low level on the gated line while the sequencer is idle starts a frame. If the line is high again when it is sampled in the middle of the start bit, the frame is dropped. Nothing is decoded and nothing is forwarded.
- R3: Each bit period lasts `CLKS_PER_BIT` clocks. The seven data bits are taken at mid-period, least significant bit first, whatever their values.
- R4: When the start-of-text code 0x02 is the first character of a message, `stx_seen` rises at the edge that ends the parity midpoint cycle of that character.
- R5: The character after start-of-text is compared with `STATION_ADDR`. On a match, `addr_ok` rises at that character's parity edge. The address character itself is not forwarded.
- R6: While in PASS, each received character (including a repeated 0x02) is forwarded. `hand_strobe` is high for exactly seven consecutive cycles, beginning in the second cycle after the parity edge. `hand_data` carries bit 0 first and bit 6 last.
- R7: A first character other than 0x02, or an address that does not match, leaves both flags low. Later characters are then discarded until an end-of-text code 0x03 arrives.
- R8: End-of-text 0x03 received in PASS is forwarded. Both flags clear at its parity edge, and the next message must start again with 0x02.
- R9: While `tx_busy` is high, the line is treated as idle-high. A character sent during that time is not received.
- R10: Shifting a bit into the character register and shifting one out never fall in the same cycle. The seven-clock handoff always ends before the next frame's first data sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial receive line, idle high |
| tx_busy | input | 1 | High while the station transmits; masks the receive line |
| hand_data | output | 1 | Serial data to the next buffer stage, valid with the strobe |
| hand_strobe | output | 1 | Shift strobe to the next buffer stage, seven cycles per character |
| stx_seen | output | 1 | Start-of-text has opened the current message |
| addr_ok | output | 1 | The station address matched; characters are being forwarded |

## Verification
The parity edge of an end-of-text character does two things in the same cycle. It arms the handoff of that character, and it clears both flags. The decision to forward must therefore use the header state from before that edge. The bench ends each forwarded message with 0x03. Its reference model expects the flags to go low at the parity edge while a full seven-bit burst of 0x03 still follows. A cycle-by-cycle compare catches either a missing burst or late-clearing flags. The second overlap is the character register's serial unload against the next frame's data sampling. Messages are sent back to back with minimal idle gaps, and a checker property forbids both shift directions in one cycle.

// File: rtl/asr_pkg.sv
package asr_pkg;
    localparam int CHAR_W = 7;
    localparam logic [CHAR_W-1:0] CODE_STX = 7'h02;
    localparam logic [CHAR_W-1:0] CODE_ETX = 7'h03;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP
    } frame_st_t;

    typedef enum logic [1:0] {
        HD_WAIT_STX,
        HD_WAIT_ADDR,
        HD_PASS,
        HD_DISCARD
    } hdr_st_t;

    typedef enum logic [1:0] {
        HO_IDLE,
        HO_ARMED,
        HO_SHIFT
    } ho_st_t;
endpackage

// File: rtl/asr_frame_seq.sv
module asr_frame_seq
    import asr_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic data_tick,
    output logic parity_tick,
    output logic frame_idle
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(CLKS_PER_BIT / 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    frame_st_t        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic             at_mid, at_end;

    assign at_mid = (cnt == MID_CNT);
    assign at_end = (cnt == LAST_CNT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            idx   <= idx_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt + 1'b1;
        idx_n   = idx;
        unique case (state)
            FR_IDLE: begin
                cnt_n = '0;
                if (!line_in) state_n = FR_START;
            end
            FR_START: begin
                if (at_mid && line_in) begin
                    state_n = FR_IDLE;
                    cnt_n   = '0;
                end else if (at_end) begin
                    state_n = FR_DATA;
                    cnt_n   = '0;
                    idx_n   = '0;
                end
            end
            FR_DATA: begin
                if (at_end) begin
                    cnt_n = '0;
                    if (idx == LAST_IDX) state_n = FR_PARITY;
                    else                 idx_n   = idx + 1'b1;
                end
            end
            FR_PARITY: begin
                if (at_end) begin
                    state_n = FR_STOP;
                    cnt_n   = '0;
                end
            end
            FR_STOP: begin
                if (at_mid) begin
                    state_n = FR_IDLE;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = FR_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        data_tick   = (state == FR_DATA)   && at_mid;
        parity_tick = (state == FR_PARITY) && at_mid;
        frame_idle  = (state == FR_IDLE);
    end
endmodule

// File: rtl/asr_char_reg.sv
module asr_char_reg #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic             in_bit,
    input  logic             shift_out,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_in) begin
            q <= {in_bit, q[WIDTH-1:1]};
        end else if (shift_out) begin
            q <= {1'b0, q[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/asr_header_fsm.sv
module asr_header_fsm
    import asr_pkg::*;
#(
    parameter logic [CHAR_W-1:0] STATION_ADDR = 7'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              parity_tick,
    input  logic [CHAR_W-1:0] ch,
    output logic              accept,
    output logic              stx_seen,
    output logic              addr_ok
);
    hdr_st_t state, state_n;
    logic    is_stx, is_etx, is_addr;

    assign is_stx  = (ch == CODE_STX);
    assign is_etx  = (ch == CODE_ETX);
    assign is_addr = (ch == STATION_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HD_WAIT_STX;
        else        state <= state_n;
    end

    // transitions, taken only at a parity midpoint
    always_comb begin
        state_n = state;
        if (parity_tick) begin
            unique case (state)
                HD_WAIT_STX: begin
                    if (is_stx)       state_n = HD_WAIT_ADDR;
                    else if (!is_etx) state_n = HD_DISCARD;
                end
                HD_WAIT_ADDR: begin
                    if (is_etx)       state_n = HD_WAIT_STX;
                    else if (is_addr) state_n = HD_PASS;
                    else              state_n = HD_DISCARD;
                end
                HD_PASS: begin
                    if (is_etx) state_n = HD_WAIT_STX;
                end
                HD_DISCARD: begin
                    if (is_etx) state_n = HD_WAIT_STX;
                end
                default: state_n = HD_WAIT_STX;
            endcase
        end
    end

    // outputs
    always_comb begin
        accept   = parity_tick && (state == HD_PASS);
        stx_seen = (state == HD_WAIT_ADDR) || (state == HD_PASS);
        addr_ok  = (state == HD_PASS);
    end
endmodule

// File: rtl/asr_handoff.sv
module asr_handoff
    import asr_pkg::*;
#(
    parameter int BURST = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic src_bit,
    output logic strobe,
    output logic data
);
    localparam int CNT_W = (BURST > 1) ? $clog2(BURST) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST - 1);

    ho_st_t           state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HO_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            HO_IDLE: begin
                cnt_n = '0;
                if (arm) state_n = HO_ARMED;
            end
            HO_ARMED: begin
                state_n = HO_SHIFT;
                cnt_n   = '0;
            end
            HO_SHIFT: begin
                if (cnt == LAST) begin
                    state_n = HO_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = HO_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        strobe = (state == HO_SHIFT);
        data   = strobe & src_bit;
    end
endmodule

// File: rtl/addr_serial_rx.sv
module addr_serial_rx
    import asr_pkg::*;
#(
    parameter int                CLKS_PER_BIT = 16,
    parameter logic [CHAR_W-1:0] STATION_ADDR = 7'h41
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic tx_busy,
    output logic hand_data,
    output logic hand_strobe,
    output logic stx_seen,
    output logic addr_ok
);
    logic              line_in;
    logic              data_tick;
    logic              parity_tick;
    logic              frame_idle;
    logic              accept;
    logic [CHAR_W-1:0] char_q;

    // R9: own transmission masks the receive line as idle-high
    assign line_in = rx_line | tx_busy;

    asr_frame_seq #(
        .CLKS_PER_BIT(CLKS_PER_BIT),
        .DATA_BITS   (CHAR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .data_tick  (data_tick),
        .parity_tick(parity_tick),
        .frame_idle (frame_idle)
    );

    asr_char_reg #(
        .WIDTH(CHAR_W)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_in (data_tick),
        .in_bit   (line_in),
        .shift_out(hand_strobe),
        .q        (char_q)
    );

    asr_header_fsm #(
        .STATION_ADDR(STATION_ADDR)
    ) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .parity_tick(parity_tick),
        .ch         (char_q),
        .accept     (accept),
        .stx_seen   (stx_seen),
        .addr_ok    (addr_ok)
    );

    asr_handoff #(
        .BURST(CHAR_W)
    ) u_ho (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (accept),
        .src_bit(char_q[0]),
        .strobe (hand_strobe),
        .data   (hand_data)
    );
endmodule

// File: rtl/asr_rx_checker.sv
module asr_rx_checker
    import asr_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic tx_busy,
    input logic data_tick,
    input logic parity_tick,
    input logic frame_idle,
    input logic hand_strobe,
    input logic stx_seen,
    input logic addr_ok
);
    logic [3:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)           run_len <= '0;
        else if (hand_strobe) run_len <= (run_len == 4'hF) ? run_len : run_len + 1'b1;
        else                  run_len <= '0;
    end

    // R6
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hand_strobe) |-> (run_len == 4'(CHAR_W)));

    // R6
    burst_after_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hand_strobe) |-> $past(parity_tick, 2));

    // R5
    addr_needs_stx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ok |-> stx_seen);

    // R4
    stx_at_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stx_seen) |-> $past(parity_tick));

    // R10
    no_shift_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_tick && hand_strobe));

    // R9
    busy_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && frame_idle) |=> frame_idle);
endmodule

bind addr_serial_rx asr_rx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_busy    (tx_busy),
    .data_tick  (data_tick),
    .parity_tick(parity_tick),
    .frame_idle (frame_idle),
    .hand_strobe(hand_strobe),
    .stx_seen   (stx_seen),
    .addr_ok    (addr_ok)
);

// File: tb/addr_serial_rx_test.sv
module addr_serial_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int RATIO      = 16;
    localparam int MID        = RATIO / 2;
    localparam logic [6:0] STA = 7'h41;
    localparam logic [6:0] STX = 7'h02;
    localparam logic [6:0] ETX = 7'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1;
    logic tx_busy = 1'b0;
    logic hand_data, hand_strobe, stx_seen, addr_ok;

    int    cyc = 0;
    int    vectors = 0;
    int    fails = 0;
    bit    checking = 1'b0;
    string cur_req = "R1";

    bit stx_at[int];
    bit addr_at[int];
    bit bit_at[int];
    bit exp_stx = 1'b0;
    bit exp_addr = 1'b0;
    int mst = 0; // 0 wait stx, 1 wait addr, 2 pass, 3 discard

    addr_serial_rx #(.CLKS_PER_BIT(RATIO), .STATION_ADDR(STA)) uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tx_busy(tx_busy),
        .hand_data(hand_data), .hand_strobe(hand_strobe),
        .stx_seen(stx_seen), .addr_ok(addr_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (checking) begin
            bit es, ed;
            if (stx_at.exists(cyc))  exp_stx  = stx_at[cyc];
            if (addr_at.exists(cyc)) exp_addr = addr_at[cyc];
            es = bit_at.exists(cyc);
            ed = es ? bit_at[cyc] : 1'b0;
            vectors++;
            if ({stx_seen, addr_ok, hand_strobe, hand_data} !== {exp_stx, exp_addr, es, ed}) begin
                fails++;
                $display("FAIL %s cycle %0d: stx,addr,strobe,data got %b%b%b%b expected %b%b%b%b",
                         cur_req, cyc, stx_seen, addr_ok, hand_strobe, hand_data,
                         exp_stx, exp_addr, es, ed);
            end
        end
    end

    // behavioural message model: schedule outputs for a character whose start edge is p
    task automatic model_char(input logic [6:0] c, input int p);
        int ep;
        ep = p + 8 * RATIO + MID + 1;
        case (mst)
            0: mst = (c == STX) ? 1 : ((c == ETX) ? 0 : 3);
            1: mst = (c == ETX) ? 0 : ((c == STA) ? 2 : 3);
            2: begin
                for (int j = 0; j < 7; j++) bit_at[ep + 1 + j] = c[j];
                if (c == ETX) mst = 0;
            end
            default: if (c == ETX) mst = 0;
        endcase
        stx_at[ep]  = (mst == 1) || (mst == 2);
        addr_at[ep] = (mst == 2);
    endtask

    task automatic send_char(input logic [6:0] c, input bit busy);
        int p;
        @(negedge clk);
        tx_busy = busy;
        rx_line = 1'b0;
        p = cyc + 1;
        if (!busy) model_char(c, p);
        for (int k = 1; k < 10; k++) begin
            repeat (RATIO) @(negedge clk);
            if (k <= 7)      rx_line = c[k-1];
            else if (k == 8) rx_line = ^c;
            else             rx_line = 1'b1;
        end
        repeat (RATIO) @(negedge clk);
        tx_busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_msg(input logic [6:0] a, input logic [6:0] d0, input logic [6:0] d1);
        send_char(STX, 1'b0);
        send_char(a, 1'b0);
        send_char(d0, 1'b0);
        send_char(d1, 1'b0);
        send_char(ETX, 1'b0);
    endtask

    initial begin
        // R1: reset values
        repeat (4) @(negedge clk);
        vectors++;
        if ({stx_seen, addr_ok, hand_strobe, hand_data} !== 4'b0000) begin
            fails++;
            $display("FAIL R1 reset: got %b%b%b%b expected 0000", stx_seen, addr_ok, hand_strobe, hand_data);
        end
        rst_n = 1'b1;
        checking = 1'b1;
        repeat (3) @(negedge clk);

        cur_req = "R3/R4/R5/R6/R8 good message";
        send_msg(STA, 7'h48, 7'h69);
        cur_req = "R3 all-ones and all-zeros data";
        send_msg(STA, 7'h7F, 7'h00);

        cur_req = "R7 wrong first character";
        send_char(7'h5A, 1'b0);
        send_char(STX, 1'b0);
        send_char(STA, 1'b0);
        send_char(7'h55, 1'b0);
        send_char(ETX, 1'b0);

        cur_req = "R7 wrong address";
        send_char(STX, 1'b0);
        send_char(7'h42, 1'b0);
        send_char(7'h2A, 1'b0);
        send_char(ETX, 1'b0);

        cur_req = "R6 repeated start code forwarded";
        send_char(STX, 1'b0);
        send_char(STA, 1'b0);
        send_char(STX, 1'b0);
        send_char(7'h55, 1'b0);

        cur_req = "R9 busy masks line";
        send_char(7'h2A, 1'b1);
        send_char(7'h15, 1'b0);

        cur_req = "R2 false start";
        @(negedge clk);
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        repeat (RATIO * 12) @(negedge clk);
        send_char(7'h33, 1'b0);

        cur_req = "R8 end of message, R10 back-to-back";
        send_char(ETX, 1'b0);
        send_msg(STA, 7'h01, 7'h40);

        repeat (20) @(negedge clk);
        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule